// File: doc/BRIEF.md
# Interface Mode Detect and Reset Sequencer

After every reset, this block decides whether a device's serial port runs as I2C or as SPI. It watches a shared address/data pin for a fixed detection window. An analog front end, which lies outside this block, reports the pin as driven low, driven high or floating. A floating pin selects SPI. A pin driven to either level selects I2C. The choice stays frozen until the next reset, so later activity on the pin cannot change it.

Glitches near the end of the window must not decide the mode. For that reason the last few samples of the window are combined by majority vote. Once the decision is made, the block announces completion on an interrupt output with a high-low-high pulse. The exception is an interrupt line that is low when the decision falls: it is then simply raised. The done flag stays low through detection and the pulse, and the serial protocol engines use it as their enable.

A synchronous hard reset starts detection. A one-cycle soft-reset request, which can arrive at any time, also starts it again.

Top module: `ifsel_rst_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs `mode_spi`, `done` and `int_drv` are all 0 after that edge. When `rst_n` returns high, a new detection window begins.
- R2: The window lasts WIN_CYC clock edges after the edge that started it, with WIN_CYC = CLK_KHZ*WIN_US/1000. The mode decision, the first interrupt response and (when there is no pulse) `done` all take effect on edge number WIN_CYC.
- R3: `sense_cls` is encoded 2'b00 driven low, 2'b01 driven high, 2'b10 floating and 2'b11 reserved. Only 2'b10 counts as floating; the other three codes count as driven.
- R4: `mode_spi` becomes 1 (SPI) when more than VOTES/2 of the last VOTES window samples are floating. Otherwise it becomes 0 (I2C).
- R5: Samples taken before the last VOTES cycles of the window have no effect on the decision.
- R6: Once decided, `mode_spi` does not change until the next hard reset, soft reset or decision, whatever `sense_cls` does.
- R7: If `int_drv` is high when the decision falls, it stays high for SEG more edges, goes low for SEG edges, then goes high again. `done` rises SEG edges after that. SEG = (CLK_KHZ*PULSE_NS/1000000)/3.
- R8: If `int_drv` is low when the decision falls, `int_drv` and `done` both go high on that same edge, with no low pulse.
- R9: A soft-reset request at any point restarts the window: `done` is 0 after that edge. `mode_spi` and the current `int_drv` level are kept until the next decision.
- R10: When a soft-reset request falls on the same edge as the window end, the restart wins. No decision is taken, `mode_spi` keeps its value and a new window starts from that edge.
- R11: `done` is 0 throughout the detection window and the completion pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst_req | input | 1 | One-cycle request to re-run detection |
| sense_cls | input | 2 | Classified level of the shared sense pin (00 low, 01 high, 10 floating, 11 reserved) |
| mode_spi | output | 1 | Latched mode: 1 = SPI, 0 = I2C |
| done | output | 1 | Detection and completion pulse finished; enables the protocol engines |
| int_drv | output | 1 | Interrupt pin drive carrying the completion pulse |

## Verification
Two things can happen on the same edge: a soft-reset request and the closing edge of a detection window. That collision decides whether a mode gets latched. The bench keeps `sense_cls` at a driven code for a whole window, which would select I2C over a latched SPI mode. It then raises the request so that it is sampled on edge WIN_CYC. After that edge, `mode_spi` must still be 1, `done` 0 and `int_drv` unchanged. A complete window counted from that same edge must then yield a fresh decision. A second overlap is also covered: a soft reset issued during the low phase of the pulse leaves `int_drv` low. The next decision must then raise `int_drv` and `done` on the same edge.

// File: rtl/ifsel_pkg.sv
// Package ifsel_pkg
// Shared codes for the interface mode detector: the classification of the
// sense pin and the states of the reset sequencer.
// Assumes the analog classifier delivers one of four two-bit codes per cycle.
package ifsel_pkg;

    // Sense pin classification codes (R3); 2'b11 is reserved and counts as driven
    localparam logic [1:0] SENSE_FLOAT_CODE = 2'b10;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_WIN   = 2'b00,
        SEQ_PULSE = 2'b01,
        SEQ_DONE  = 2'b10
    } seq_state_e;

    // True only for the floating code
    function automatic logic sense_is_float(input logic [1:0] code);
        return code == SENSE_FLOAT_CODE;
    endfunction

endpackage

// File: rtl/ifsel_win_timer.sv
// Module ifsel_win_timer
// Counts the detection window. It flags the cycles whose sense samples enter
// the vote and the final cycle, on which the decision is taken.
// Assumes WIN_CYC >= VOTES and WIN_CYC >= 2; restart has priority over counting.
module ifsel_win_timer #(
    parameter int WIN_CYC = 250,
    parameter int VOTES   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic vote_en,
    output logic win_end
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] LAST_IDX  = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] FIRST_VOT = CW'(WIN_CYC - VOTES);

    logic [CW-1:0] cnt;

    // Window position counter: cleared by either reset, advanced while running
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (run && cnt != LAST_IDX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Decode of the vote span and the last window cycle
    always_comb begin
        vote_en = run && (cnt >= FIRST_VOT);
        win_end = run && (cnt == LAST_IDX);
    end

    // R2: a window ends on one single edge, never on two in a row
    assert_window_end_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> !win_end);

endmodule

// File: rtl/ifsel_vote.sv
// Module ifsel_vote
// Tallies the floating samples across the vote span and presents the majority
// result, counting the sample taken in the current cycle as well.
// Assumes VOTES is odd, so that no vote can end in a tie.
module ifsel_vote #(
    parameter int VOTES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample_en,
    input  logic is_float,
    output logic spi_vote
);
    localparam int TW = $clog2(VOTES + 1);
    localparam logic [TW:0] HALF = (TW+1)'(VOTES / 2);

    logic [TW-1:0] tally;
    logic          hit;
    logic [TW:0]   sum;

    // Combine the stored tally with the present sample
    always_comb begin
        hit      = sample_en && is_float;
        sum      = {1'b0, tally} + (TW+1)'(hit);
        spi_vote = sum > HALF;
    end

    // Floating-sample tally, emptied at restart and after each decision
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tally <= '0;
        end else if (hit) begin
            tally <= tally + 1'b1;
        end
    end

    // R4: the tally never holds more samples than the vote span
    assert_tally_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tally <= TW'(VOTES));

endmodule

// File: rtl/ifsel_pulse_gen.sv
// Module ifsel_pulse_gen
// Owns the interrupt drive. It plays the high-low-high completion pulse in three
// segments of SEG cycles each, or raises the line at once when told to.
// Assumes start and set_high never arrive together; abort has priority.
module ifsel_pulse_gen #(
    parameter int SEG = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic set_high,
    input  logic abort,
    output logic int_drv,
    output logic fin
);
    localparam int PW = $clog2(3 * SEG);
    localparam logic [PW-1:0] LOW_AT  = PW'(SEG - 1);
    localparam logic [PW-1:0] HIGH_AT = PW'(2 * SEG - 1);
    localparam logic [PW-1:0] END_AT  = PW'(3 * SEG - 1);

    logic          active;
    logic [PW-1:0] pcnt;

    // Pulse segment counter and interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_drv <= 1'b0;
            active  <= 1'b0;
            pcnt    <= '0;
        end else if (abort) begin
            active  <= 1'b0;
        end else if (start) begin
            active  <= 1'b1;
            pcnt    <= '0;
        end else if (set_high) begin
            int_drv <= 1'b1;
        end else if (active) begin
            pcnt <= pcnt + 1'b1;
            if (pcnt == LOW_AT) begin
                int_drv <= 1'b0;
            end
            if (pcnt == HIGH_AT) begin
                int_drv <= 1'b1;
            end
            if (pcnt == END_AT) begin
                active <= 1'b0;
            end
        end
    end

    // Completion strobe on the last pulse cycle
    always_comb begin
        fin = active && (pcnt == END_AT) && !abort;
    end

    // R7: the line only falls while a completion pulse is running
    assert_low_only_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_drv) |-> $past(active));

endmodule

// File: rtl/ifsel_rst_seq.sv
// Module ifsel_rst_seq
// Top of the interface mode detector. It runs the detection window after a hard
// or soft reset, latches the majority-voted mode and then sequences the
// completion pulse before raising done.
// Assumes rst_n is synchronous, and that soft_rst_req is synchronous and may be
// held or repeated at any time.
module ifsel_rst_seq
    import ifsel_pkg::*;
#(
    parameter int CLK_KHZ  = 50000,
    parameter int WIN_US   = 1000,
    parameter int PULSE_NS = 500,
    parameter int VOTES    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst_req,
    input  logic [1:0] sense_cls,
    output logic       mode_spi,
    output logic       done,
    output logic       int_drv
);
    localparam int WIN_RAW   = CLK_KHZ * WIN_US / 1000;
    localparam int WIN_CYC   = (WIN_RAW < VOTES + 1) ? VOTES + 1 : WIN_RAW;
    localparam int PULSE_CYC = CLK_KHZ * PULSE_NS / 1000000;
    localparam int SEG       = (PULSE_CYC / 3 < 1) ? 1 : PULSE_CYC / 3;

    seq_state_e st;
    logic run, vote_en, win_end, vote_spi, decide, pulse_fin;

    // Decision qualifiers; a restart on the closing edge cancels the decision
    always_comb begin
        run    = (st == SEQ_WIN);
        decide = win_end && !soft_rst_req;
        done   = (st == SEQ_DONE);
    end

    ifsel_win_timer #(.WIN_CYC(WIN_CYC), .VOTES(VOTES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (soft_rst_req),
        .run     (run),
        .vote_en (vote_en),
        .win_end (win_end)
    );

    ifsel_vote #(.VOTES(VOTES)) vote_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (soft_rst_req || win_end),
        .sample_en (vote_en),
        .is_float  (sense_is_float(sense_cls)),
        .spi_vote  (vote_spi)
    );

    ifsel_pulse_gen #(.SEG(SEG)) pulse_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (decide && int_drv),
        .set_high (decide && !int_drv),
        .abort    (soft_rst_req),
        .int_drv  (int_drv),
        .fin      (pulse_fin)
    );

    // Sequencer: window, then pulse or straight to done
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_req) begin
            st <= SEQ_WIN;
        end else begin
            case (st)
                SEQ_WIN:   if (win_end)   st <= int_drv ? SEQ_PULSE : SEQ_DONE;
                SEQ_PULSE: if (pulse_fin) st <= SEQ_DONE;
                default:   st <= SEQ_DONE;
            endcase
        end
    end

    // Mode latch, written once per completed window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_spi <= 1'b0;
        end else if (decide) begin
            mode_spi <= vote_spi;
        end
    end

    // R9: a soft-reset request leaves done low on the next cycle
    assert_soft_clears_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |=> !done);

    // R6: after completion the mode stays put without a reset
    assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !soft_rst_req) |=> $stable(mode_spi));

    // R10: a restart on the closing edge keeps the old mode
    assert_restart_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && soft_rst_req) |=> $stable(mode_spi));

    // R8: done only rises with the interrupt line high
    assert_done_with_int_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> int_drv);

    // R11: the interrupt line never falls once done is up
    assert_no_fall_when_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_drv) |-> !done);

endmodule

// File: tb/ifsel_rst_seq_tb_top.sv
// Bench for ifsel_rst_seq: sweeps all vote patterns in a small configuration and
// checks the window, pulse and reset overlaps cycle by cycle.
module ifsel_rst_seq_tb_top;
    localparam int CLK_KHZ  = 250000;
    localparam int WIN_US   = 1;
    localparam int PULSE_NS = 96;
    localparam int VOTES    = 5;
    localparam int WIN      = CLK_KHZ * WIN_US / 1000;
    localparam int SEG      = (CLK_KHZ * PULSE_NS / 1000000) / 3;

    logic       clk = 1'b0;
    logic       rst_n, soft_rst_req;
    logic [1:0] sense_cls;
    logic       mode_spi, done, int_drv;
    int         n_chk = 0;
    int         n_fail = 0;
    logic       exp_mode;
    logic       got;

    always #2 clk = ~clk;

    ifsel_rst_seq #(.CLK_KHZ(CLK_KHZ), .WIN_US(WIN_US), .PULSE_NS(PULSE_NS),
                    .VOTES(VOTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst_req(soft_rst_req),
        .sense_cls(sense_cls), .mode_spi(mode_spi), .done(done), .int_drv(int_drv)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic soft_pulse();
        soft_rst_req = 1'b1;
        tick();
        soft_rst_req = 1'b0;
    endtask

    // Runs one window; before the vote span it drives the opposite of the majority
    task automatic window(input logic [4:0] pat, input logic [1:0] drv,
                          input logic prev, output logic want);
        want = ($countones(pat) >= 3);
        for (int i = 1; i <= WIN; i++) begin
            if (i > WIN - VOTES) sense_cls = pat[i - (WIN - VOTES) - 1] ? 2'b10 : drv;
            else                 sense_cls = want ? drv : 2'b10;
            tick();
            if (i == WIN - 1) begin
                check("R11 done low in window", done, 1'b0);
                check("R9 mode kept in window", mode_spi, prev);
            end
        end
        check("R4 R3 R5 voted mode", mode_spi, want);
    endtask

    // Follows a full completion pulse from the decision edge
    task automatic pulse_seq();
        check("R7 int high at decision", int_drv, 1'b1);
        check("R2 R11 done low at decision", done, 1'b0);
        for (int j = 1; j <= 3 * SEG; j++) begin
            tick();
            check("R7 pulse level", int_drv, (j >= SEG && j < 2 * SEG) ? 1'b0 : 1'b1);
            check("R7 R11 done timing", done, (j == 3 * SEG) ? 1'b1 : 1'b0);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        soft_rst_req = 1'b0;
        sense_cls = 2'b00;
        repeat (3) tick();
        check("R1 mode after reset", mode_spi, 1'b0);
        check("R1 done after reset", done, 1'b0);
        check("R1 int after reset", int_drv, 1'b0);
        rst_n = 1'b1;
        window(5'b11111, 2'b00, 1'b0, got);
        check("R8 int raised at decision", int_drv, 1'b1);
        check("R8 R2 done at decision", done, 1'b1);
        exp_mode = got;

        // R4 sweep of every vote pattern, rotating the driven code (R3)
        for (int p = 0; p < 32; p++) begin
            soft_pulse();
            window(5'(p), (p % 3 == 0) ? 2'b00 : ((p % 3 == 1) ? 2'b01 : 2'b11),
                   exp_mode, got);
            pulse_seq();
            exp_mode = got;
        end

        // R6: sense activity after completion
        for (int k = 0; k < 20; k++) begin
            sense_cls = (k % 2 == 0) ? 2'b10 : 2'b00;
            tick();
            check("R6 mode frozen", mode_spi, exp_mode);
            check("R6 done held", done, 1'b1);
        end

        // R9: restart in the middle of a window
        soft_pulse();
        sense_cls = 2'b10;
        repeat (100) tick();
        soft_pulse();
        check("R9 done low after restart", done, 1'b0);
        window(5'b00000, 2'b01, exp_mode, got);
        pulse_seq();
        exp_mode = got;

        // R9 and R8: restart during the low phase of the pulse
        soft_pulse();
        window(5'b11111, 2'b00, exp_mode, got);
        exp_mode = got;
        repeat (SEG + 2) tick();
        check("R7 int low mid pulse", int_drv, 1'b0);
        soft_pulse();
        check("R9 int level kept", int_drv, 1'b0);
        check("R9 done low", done, 1'b0);
        window(5'b00111, 2'b01, exp_mode, got);
        check("R8 int raised without pulse", int_drv, 1'b1);
        check("R8 done with int", done, 1'b1);
        exp_mode = got;

        // R10: restart on the closing edge of a window
        soft_pulse();
        for (int i = 1; i <= WIN; i++) begin
            sense_cls = 2'b00;
            if (i == WIN) soft_rst_req = 1'b1;
            tick();
        end
        soft_rst_req = 1'b0;
        check("R10 mode unchanged", mode_spi, exp_mode);
        check("R10 done low", done, 1'b0);
        check("R10 int unchanged", int_drv, 1'b1);
        window(5'b00011, 2'b11, exp_mode, got);
        pulse_seq();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule